// File: doc/BRIEF.md
# Host/BMC Byte Mailbox with Status Notification

This block is a small register mailbox that links a host-facing register port with a management-controller (BMC) facing register port. Each direction has one byte of data storage: the host deposits a byte that the BMC collects, and the BMC deposits a byte that the host collects. A status byte is visible from both ports. Its two low bits are full flags kept by hardware, and its upper six bits are protocol state that only the BMC may change.

Each full flag drives a level interrupt towards the side that must collect the byte. Reading the data register on the collecting side clears the flag. A write to the status byte alone raises no interrupt. To announce a status change, the BMC uses a notify strobe. In a single cycle it updates the upper status bits and loads a reserved notify code into the outbound data register, which raises the host interrupt. The host then sees the notify indication, reads the status byte again and collects the code. If the BMC loads the outbound register while the host has not yet collected the previous byte, the block reports an overrun.

Top module: `mbx_kcs_regs`

## Requirements
- R1: After reset the inbound and outbound data registers, both full flags, the six software status bits, both interrupts, the overrun output and the notify indication are all zero.
- R2: A host write with select 0 (data) stores the write byte as the inbound byte and sets the inbound-full flag (status bit 1) from the next clock edge on. The BMC port reads that byte with select 0.
- R3: A BMC read with select 0 clears the inbound-full flag at the next edge. A BMC read with select 1 (status) leaves the flag unchanged.
- R4: A BMC write with select 0 stores the write byte as the outbound byte and sets the outbound-full flag (status bit 0) from the next edge on. The host port reads that byte with select 0.
- R5: A host read with select 0 clears the outbound-full flag at the next edge. A host read with select 1 leaves it unchanged.
- R6: A BMC write with select 1 loads write bits 7:2 into status bits 7:2 and ignores write bits 1:0. Both ports read the same status byte with select 1.
- R7: Host writes with select 1 change nothing: status, flags and interrupts stay as they were.
- R8: A BMC notify strobe loads b_wdata[7:2] into status bits 7:2 and loads NOTIFY_CODE (default 8'hFF) as the outbound byte, which sets the outbound-full flag. It takes priority over a BMC write in the same cycle. h_notify is high while the outbound flag is set and the outbound byte equals NOTIFY_CODE.
- R9: A BMC load of the outbound byte while the outbound flag is set, with no host data read in the same cycle, replaces the byte, keeps the flag set and raises ob_overrun for exactly the one cycle after that edge.
- R10: A load and a collecting read of the same data register in the same cycle leave the new byte stored with its flag set, and raise no overrun.
- R11: b_irq equals the inbound-full flag and h_irq equals the outbound-full flag at all times. Neither rises without a data load on the opposite port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_sel | input | 1 | Host register select: 0 data, 1 status |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte (outbound data or status) |
| h_irq | output | 1 | Host interrupt, level, equals outbound-full flag |
| h_notify | output | 1 | Outbound byte is the notify code and is uncollected |
| b_wr | input | 1 | BMC write strobe, one cycle |
| b_rd | input | 1 | BMC read strobe, one cycle |
| b_sel | input | 1 | BMC register select: 0 data, 1 status |
| b_notify | input | 1 | BMC status-change notify strobe |
| b_wdata | input | 8 | BMC write byte / notify status bits |
| b_rdata | output | 8 | BMC read byte (inbound data or status) |
| b_irq | output | 1 | BMC interrupt, level, equals inbound-full flag |
| ob_overrun | output | 1 | One-cycle pulse: outbound byte overwritten uncollected |

## Verification
Every strobe takes effect at the first rising edge after the cycle in which it is held. Flags, stored bytes, status bits, the interrupts, the notify indication and the overrun pulse therefore all show the new value one cycle after the stimulus, and the overrun pulse is gone one cycle later. The read-data outputs are combinational views of stored state. The bench drives each strobe on a falling edge and drops it on the next falling edge, so at that point exactly one rising edge has passed, and it checks there. For the overrun it checks a second time one cycle later to confirm the pulse has ended.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // register select codes shared by both ports
    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_STAT = 1'b1;
    // hardware flag positions inside the status byte
    localparam int unsigned OBF_POS = 0;
    localparam int unsigned IBF_POS = 1;
    localparam int unsigned SW_LSB  = 2;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         take_i,
    output logic [W-1:0] val_o,
    output logic         full_o
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         full;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.val  = load_val_i;
            st_d.full = 1'b1;
        end else if (take_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o  = st_q.val;
    assign full_o = st_q.full;

    // R2 / R4: a load stores the byte and marks the slot full
    assert_load_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (full_o && val_o == $past(load_val_i)));
    // R3 / R5: a collecting read without a load empties the slot
    assert_take_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !load_i) |=> !full_o);
    // R10: load wins over a same-cycle collect
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && take_i) |=> full_o);
    // no strobe, no change
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !take_i) |=> ($stable(full_o) && $stable(val_o)));
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
    parameter int unsigned SW_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic            notify_i,
    input  logic [SW_W-1:0] bits_i,
    output logic [SW_W-1:0] sw_o
);
    typedef struct packed {
        logic [SW_W-1:0] sw;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (notify_i || wr_i) st_d.sw = bits_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_o = st_q.sw;

    // R6 / R7: software bits move only on a BMC status write or notify
    assert_sw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !notify_i) |=> $stable(sw_o));
    // R8: notify carries the new status bits
    assert_notify_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        notify_i |=> (sw_o == $past(bits_i)));
endmodule

// File: rtl/mbx_kcs_regs.sv
module mbx_kcs_regs #(
    parameter int unsigned DW          = 8,
    parameter logic [7:0]  NOTIFY_CODE = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic          h_sel,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_irq,
    output logic          h_notify,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic          b_sel,
    input  logic          b_notify,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq,
    output logic          ob_overrun
);
    import mbx_pkg::*;

    localparam int unsigned SW_W = DW - SW_LSB;
    localparam logic [DW-1:0] NOTE = DW'(NOTIFY_CODE);

    typedef struct packed {
        logic overrun;
    } top_t;

    top_t st_d, st_q;

    logic          ib_load, ib_take, ib_full;
    logic [DW-1:0] ib_val;
    logic          ob_load, ob_take, ob_full;
    logic [DW-1:0] ob_val, ob_load_val;
    logic          st_wr;
    logic [SW_W-1:0] sw_bits;
    logic [DW-1:0] stat_byte;

    // strobe decode
    always_comb begin
        ib_load     = h_wr && (h_sel == SEL_DATA);
        ib_take     = b_rd && (b_sel == SEL_DATA);
        ob_load     = b_notify || (b_wr && (b_sel == SEL_DATA));
        ob_load_val = b_notify ? NOTE : b_wdata;
        ob_take     = h_rd && (h_sel == SEL_DATA);
        st_wr       = b_wr && (b_sel == SEL_STAT) && !b_notify;
    end

    mbx_slot #(.W(DW)) u_inbound (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ib_load),
        .load_val_i (h_wdata),
        .take_i     (ib_take),
        .val_o      (ib_val),
        .full_o     (ib_full)
    );

    mbx_slot #(.W(DW)) u_outbound (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ob_load),
        .load_val_i (ob_load_val),
        .take_i     (ob_take),
        .val_o      (ob_val),
        .full_o     (ob_full)
    );

    mbx_status #(.SW_W(SW_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (st_wr),
        .notify_i (b_notify),
        .bits_i   (b_wdata[DW-1:SW_LSB]),
        .sw_o     (sw_bits)
    );

    // status byte assembly and overrun next state
    always_comb begin
        stat_byte               = '0;
        stat_byte[DW-1:SW_LSB]  = sw_bits;
        stat_byte[IBF_POS]      = ib_full;
        stat_byte[OBF_POS]      = ob_full;
        st_d.overrun            = ob_load && ob_full && !ob_take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_rdata    = (h_sel == SEL_STAT) ? stat_byte : ob_val;
    assign b_rdata    = (b_sel == SEL_STAT) ? stat_byte : ib_val;
    assign h_irq      = ob_full;
    assign b_irq      = ib_full;
    assign h_notify   = ob_full && (ob_val == NOTE);
    assign ob_overrun = st_q.overrun;

    // R7: host status writes leave the software bits alone
    assert_host_stat_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_sel && !b_notify && !(b_wr && b_sel)) |=> $stable(b_rdata[DW-1:SW_LSB] & {SW_W{b_sel}}) || !b_sel);
    // R9: uncollected outbound byte overwritten -> overrun pulse
    assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_notify || (b_wr && !b_sel)) && h_irq && !(h_rd && !h_sel)) |=> ob_overrun);
    // R10: same-cycle host collect suppresses overrun
    assert_no_overrun_on_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && !h_sel) |=> !ob_overrun);
    // R8: notify always yields the host notify indication
    assert_notify_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        b_notify |=> (h_notify && h_irq));
    // R11: interrupts rise only after a load on the opposite port
    assert_birq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_irq) |-> $past(h_wr && !h_sel));
    assert_hirq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_irq) |-> $past(b_notify || (b_wr && !b_sel)));
endmodule

// File: tb/test_mbx_kcs_regs.sv
module test_mbx_kcs_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] NOTE = 8'hFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_wr = 0, h_rd = 0, h_sel = 0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic       h_irq, h_notify;
    logic       b_wr = 0, b_rd = 0, b_sel = 0, b_notify = 0;
    logic [7:0] b_wdata = '0;
    logic [7:0] b_rdata;
    logic       b_irq, ob_overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    mbx_kcs_regs #(.DW(8), .NOTIFY_CODE(NOTE)) i_mbx_kcs_regs (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_rd(h_rd), .h_sel(h_sel), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq), .h_notify(h_notify),
        .b_wr(b_wr), .b_rd(b_rd), .b_sel(b_sel), .b_notify(b_notify),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq),
        .ob_overrun(ob_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // strobes are raised on a falling edge and dropped on the next one
    task automatic host_wr(input logic sel, input logic [7:0] v);
        @(negedge clk); h_wr = 1; h_sel = sel; h_wdata = v;
        @(negedge clk); h_wr = 0; h_sel = 0;
    endtask
    task automatic host_rd(input logic sel);
        @(negedge clk); h_rd = 1; h_sel = sel;
        @(negedge clk); h_rd = 0; h_sel = 0;
    endtask
    task automatic bmc_wr(input logic sel, input logic [7:0] v);
        @(negedge clk); b_wr = 1; b_sel = sel; b_wdata = v;
        @(negedge clk); b_wr = 0; b_sel = 0;
    endtask
    task automatic bmc_rd(input logic sel);
        @(negedge clk); b_rd = 1; b_sel = sel;
        @(negedge clk); b_rd = 0; b_sel = 0;
    endtask
    task automatic bmc_note(input logic [7:0] v);
        @(negedge clk); b_notify = 1; b_wdata = v;
        @(negedge clk); b_notify = 0;
    endtask
    task automatic status_both(input string req, input logic [7:0] exp);
        h_sel = 1; b_sel = 1; #1;
        chk(req, h_rdata, exp);
        chk(req, b_rdata, exp);
        h_sel = 0; b_sel = 0; #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin : main
        logic [5:0] sw;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        status_both("R1", 8'h00);
        chk("R1", h_irq, 0); chk("R1", b_irq, 0);
        chk("R1", ob_overrun, 0); chk("R1", h_notify, 0);
        chk("R1", h_rdata, 8'h00); chk("R1", b_rdata, 8'h00);

        // inbound sweep: R2, R3, R11
        for (int v = 0; v < 256; v++) begin
            host_wr(0, v[7:0]);
            chk("R11", b_irq, 1);
            chk("R2", b_rdata, v[7:0]);
            status_both("R2", 8'h02);
            bmc_rd(1);
            chk("R3", b_irq, 1);
            bmc_rd(0);
            chk("R3", b_irq, 0);
            chk("R11", h_irq, 0);
        end

        // outbound sweep: R4, R5, R8 indication, R11
        for (int v = 0; v < 256; v++) begin
            bmc_wr(0, v[7:0]);
            chk("R11", h_irq, 1);
            chk("R4", h_rdata, v[7:0]);
            chk("R9", ob_overrun, 0);
            chk("R8", h_notify, (v[7:0] == NOTE) ? 1 : 0);
            status_both("R4", 8'h01);
            host_rd(1);
            chk("R5", h_irq, 1);
            host_rd(0);
            chk("R5", h_irq, 0);
            chk("R8", h_notify, 0);
            chk("R11", b_irq, 0);
        end

        // status sweep: R6, R7
        for (int s = 0; s < 64; s++) begin
            bmc_wr(1, {s[5:0], 2'b11});
            status_both("R6", {s[5:0], 2'b00});
            chk("R6", h_irq, 0); chk("R6", b_irq, 0);
            host_wr(1, ~{s[5:0], 2'b00});
            status_both("R7", {s[5:0], 2'b00});
            chk("R7", h_irq, 0); chk("R7", b_irq, 0);
        end

        // notify path: R8
        bmc_note(8'hA8);
        chk("R8", h_notify, 1); chk("R8", h_irq, 1);
        status_both("R8", 8'hA9);
        chk("R8", h_rdata, NOTE);
        host_rd(0);
        chk("R8", h_notify, 0); chk("R8", h_irq, 0);
        // notify beats a same-cycle data write
        @(negedge clk); b_notify = 1; b_wr = 1; b_sel = 0; b_wdata = 8'h14;
        @(negedge clk); b_notify = 0; b_wr = 0;
        chk("R8", h_rdata, NOTE);
        status_both("R8", 8'h15);
        host_rd(0);

        // overrun: R9
        bmc_wr(0, 8'h10);
        chk("R9", ob_overrun, 0);
        bmc_wr(0, 8'h20);
        chk("R9", ob_overrun, 1);
        chk("R9", h_rdata, 8'h20);
        chk("R9", h_irq, 1);
        @(negedge clk);
        chk("R9", ob_overrun, 0);

        // simultaneous load and collect: R10
        @(negedge clk); b_wr = 1; b_sel = 0; b_wdata = 8'h30; h_rd = 1; h_sel = 0;
        @(negedge clk); b_wr = 0; h_rd = 0;
        chk("R10", h_irq, 1); chk("R10", h_rdata, 8'h30);
        chk("R10", ob_overrun, 0);
        host_rd(0);
        host_wr(0, 8'h41);
        @(negedge clk); h_wr = 1; h_sel = 0; h_wdata = 8'h42; b_rd = 1; b_sel = 0;
        @(negedge clk); h_wr = 0; b_rd = 0;
        chk("R10", b_irq, 1); chk("R10", b_rdata, 8'h42);
        bmc_rd(0);
        chk("R10", b_irq, 0);

        finished = 1;
        finish_run();
    end
endmodule